// File: doc/BRIEF.md
# Byte-Wide Serial Transceiver Core with Loopback Routing

This block is the digital heart of a byte-wide serial link. A transmit serializer turns parallel bytes into a bit stream, most significant bit first. A receive deserializer rebuilds parallel bytes from an incoming bit stream and marks each new byte with a one-cycle strobe. Everything runs on a single serial-rate clock. The actual bit timing comes from two enables: a local tick, standing in for the locally multiplied clock, and a recovered tick, standing in for the clock extracted from the received data. Each byte period is eight ticks long, so the byte clock is the bit clock divided by eight.

Four mode inputs change how the data is routed:
- **Facility loopback** sends the retimed received bits straight out of the transmit pin.
- **Parallel-side equipment loopback** feeds the serialized transmit stream into the deserializer, with byte timing taken from the transmit clock.
- **High-speed-side equipment loopback** injects the transmit stream ahead of the receive retiming stages, in place of the external receive data.
- **Loop timing** drives the serializer from the recovered tick instead of the local one.

The receive byte boundary is set by a free-running divide-by-eight counter. An align pulse moves that boundary.

Top module: `byte_serdes_core`

## Requirements
- R1: Each byte on `tx_byte` is sent on `tx_ser_out` most significant bit first, one bit per transmit tick. `tx_take` is high exactly while the next transmit tick will capture `tx_byte`. A bit taken at a tick edge appears on `tx_ser_out` after the following rising edge.
- R2: The transmit tick is `loc_tick` when `loop_time` is low. When `loop_time` is high it is `rec_tick`, and `loc_tick` then has no effect on `tx_ser_out`.
- R3: The receiver shifts bits in most significant bit first and closes a byte every eight receive ticks. With the default two retiming stages, a pulse on `rx_align` makes the bit that was on `rx_ser_in` one tick earlier the most significant bit of the next byte.
- R4: With default parameters, the most significant bit of a byte sampled from `rx_ser_in` at edge t produces that byte on `rx_byte` after edge t+25. This is inside the 25 to 35 cycle bound.
- R5: `rx_stb` is a single-cycle pulse that updates on the same edge as `rx_byte`. `rx_byte` holds its value for the rest of the byte period.
- R6: With `fac_loop` high, the bit sampled on `rx_ser_in` at edge t appears on `tx_ser_out` after edge t+2, which is three edges and inside the 2 to 4 cycle bound. `tx_byte` has no effect on the output.
- R7: With `eq_loop` high, the deserializer takes the serialized transmit stream, counted on transmit ticks. An align pulse on a byte-load edge L gives byte k on `rx_byte` after edge L+24+8k. `tx_ser_out` keeps carrying the transmit data.
- R8: With `eq_loop_hs` high, the transmit stream replaces `rx_ser_in` ahead of the retiming stages, and `rx_ser_in` has no effect. An align pulse at edge L+2 gives byte k after edge L+26+8k.
- R9: With `fac_loop` and `eq_loop` both high, both loopbacks work at once: received bits go out on `tx_ser_out` as in R6, and transmit bytes come back on `rx_byte` as in R7.
- R10: After reset, `tx_ser_out`, `rx_byte` and `rx_stb` are zero and `tx_take` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_tick | input | 1 | Local bit-clock enable |
| rec_tick | input | 1 | Recovered bit-clock enable |
| fac_loop | input | 1 | Receive-to-transmit loopback select |
| eq_loop | input | 1 | Transmit-to-deserializer loopback select |
| eq_loop_hs | input | 1 | Transmit-to-receive-input loopback select |
| loop_time | input | 1 | Serializer timed by recovered tick |
| rx_align | input | 1 | Restart receive byte count |
| tx_byte | input | W | Parallel transmit byte |
| rx_ser_in | input | 1 | Serial receive data |
| tx_take | output | 1 | Next transmit tick captures `tx_byte` |
| tx_ser_out | output | 1 | Serial transmit data |
| rx_byte | output | W | Parallel receive byte |
| rx_stb | output | 1 | New receive byte pulse |

## Verification
The assertions assume that the mode inputs change only while reset is held. They also assume that `rx_align` is pulsed only on purpose, because a pulse on a boundary edge withholds that byte's strobe. The stimulus sets every mode before releasing reset and re-applies reset between scenarios. It pulses `rx_align` exactly once per scenario, on the edge its timing model predicts. The tick enables are gapped only in the transmit-timing scenarios, where byte alignment on the receive side is not checked.

// File: rtl/byte_serdes_pkg.sv
package byte_serdes_pkg;
  typedef struct packed {
    logic fac;
    logic eq;
    logic eq_hs;
    logic lt;
  } bsd_mode_t;

  function automatic logic tx_tick_sel(input bsd_mode_t m, input logic loc, input logic rec);
    return m.lt ? rec : loc;
  endfunction
endpackage

// File: rtl/bsd_tx_ser.sv
module bsd_tx_ser #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] din,
  output logic         bit_o,
  output logic         take_o
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt;
  logic [W-1:0]  sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      sh     <= '0;
      bit_o  <= 1'b0;
      take_o <= 1'b1;
    end else if (tick) begin
      if (cnt == '0) begin
        bit_o <= din[W-1];
        sh    <= {din[W-2:0], 1'b0};
      end else begin
        bit_o <= sh[W-1];
        sh    <= {sh[W-2:0], 1'b0};
      end
      cnt    <= (cnt == LAST) ? '0 : cnt + 1'b1;
      take_o <= (cnt == LAST);
    end
  end
endmodule

// File: rtl/bsd_retime.sv
module bsd_retime #(
  parameter int N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic d,
  output logic q
);
  logic [N-1:0] st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= '0;
    end else if (tick) begin
      st[0] <= d;
      for (int i = 1; i < N; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[N-1];
endmodule

// File: rtl/bsd_rx_deser.sv
module bsd_rx_deser #(
  parameter int W    = 8,
  parameter int PIPE = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         align,
  input  logic         din,
  output logic [W-1:0] byte_o,
  output logic         stb_o
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt;
  logic [W-2:0]  sh;
  logic [W-1:0]  pipe [PIPE];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      sh    <= '0;
      stb_o <= 1'b0;
      for (int i = 0; i < PIPE; i++) pipe[i] <= '0;
    end else begin
      stb_o <= 1'b0;
      if (tick) sh <= {sh[W-3:0], din};
      if (align) begin
        cnt <= '0;
      end else if (tick) begin
        cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        if (cnt == LAST) begin
          pipe[0] <= {sh, din};
          for (int i = 1; i < PIPE; i++) pipe[i] <= pipe[i-1];
          stb_o <= 1'b1;
        end
      end
    end
  end

  assign byte_o = pipe[PIPE-1];
endmodule

// File: rtl/byte_serdes_core.sv
module byte_serdes_core
  import byte_serdes_pkg::*;
#(
  parameter int W          = 8,
  parameter int RET_STAGES = 2,
  parameter int PIPE_BYTES = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         loc_tick,
  input  logic         rec_tick,
  input  logic         fac_loop,
  input  logic         eq_loop,
  input  logic         eq_loop_hs,
  input  logic         loop_time,
  input  logic         rx_align,
  input  logic [W-1:0] tx_byte,
  input  logic         rx_ser_in,
  output logic         tx_take,
  output logic         tx_ser_out,
  output logic [W-1:0] rx_byte,
  output logic         rx_stb
);
  bsd_mode_t mode;
  logic tx_tick, rx_tick, tx_bit, rx_src, ret_bit, des_in;

  assign mode    = '{fac: fac_loop, eq: eq_loop, eq_hs: eq_loop_hs, lt: loop_time};
  assign tx_tick = tx_tick_sel(mode, loc_tick, rec_tick);
  // Receive timing follows the transmit clock whenever transmit data is looped in.
  assign rx_tick = (mode.eq || mode.eq_hs) ? tx_tick : rec_tick;
  assign rx_src  = mode.eq_hs ? tx_bit : rx_ser_in;
  assign des_in  = mode.eq ? tx_bit : ret_bit;

  bsd_tx_ser #(.W(W)) u_tx (
    .clk(clk), .rst(rst), .tick(tx_tick), .din(tx_byte),
    .bit_o(tx_bit), .take_o(tx_take)
  );

  bsd_retime #(.N(RET_STAGES)) u_ret (
    .clk(clk), .rst(rst), .tick(rx_tick), .d(rx_src), .q(ret_bit)
  );

  bsd_rx_deser #(.W(W), .PIPE(PIPE_BYTES)) u_rx (
    .clk(clk), .rst(rst), .tick(rx_tick), .align(rx_align), .din(des_in),
    .byte_o(rx_byte), .stb_o(rx_stb)
  );

  always_ff @(posedge clk) begin
    if (rst) tx_ser_out <= 1'b0;
    else     tx_ser_out <= mode.fac ? ret_bit : tx_bit;
  end
endmodule

// File: rtl/bsd_checker.sv
module bsd_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         loc_tick,
  input logic         rec_tick,
  input logic         fac_loop,
  input logic         eq_loop,
  input logic         eq_loop_hs,
  input logic         loop_time,
  input logic         rx_ser_in,
  input logic         tx_take,
  input logic         tx_ser_out,
  input logic [W-1:0] rx_byte,
  input logic         rx_stb
);
  logic [1:0] since;

  always_ff @(posedge clk) begin
    if (rst) since <= '0;
    else if (since != 2'd3) since <= since + 1'b1;
  end

  // R5: strobe lasts one cycle
  assert_stb_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    rx_stb |=> !rx_stb);

  // R5: byte only moves together with the strobe
  assert_byte_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (since != 2'd0 && !rx_stb) |-> $stable(rx_byte));

  // R1: a capture tick clears the take flag
  assert_take_clear_R1: assert property (@(posedge clk) disable iff (rst)
    (tx_take && (loop_time ? rec_tick : loc_tick)) |=> !tx_take);

  // R6: facility path delay of three edges
  assert_fac_delay_R6: assert property (@(posedge clk) disable iff (rst)
    (since == 2'd3 && $past(fac_loop) && $past(rec_tick,2) && $past(rec_tick,3)
     && !$past(eq_loop,2) && !$past(eq_loop_hs,2) && !$past(eq_loop,3)
     && !$past(eq_loop_hs,3))
    |-> tx_ser_out == $past(rx_ser_in,3));

  // R2: in loop timing, no recovered tick means no serial change
  assert_loop_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (since == 2'd3 && !$past(fac_loop) && !$past(fac_loop,2)
     && $past(loop_time,2) && !$past(rec_tick,2))
    |-> $stable(tx_ser_out));
endmodule

bind byte_serdes_core bsd_checker #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .loc_tick(loc_tick), .rec_tick(rec_tick),
  .fac_loop(fac_loop), .eq_loop(eq_loop), .eq_loop_hs(eq_loop_hs),
  .loop_time(loop_time), .rx_ser_in(rx_ser_in), .tx_take(tx_take),
  .tx_ser_out(tx_ser_out), .rx_byte(rx_byte), .rx_stb(rx_stb)
);

// File: tb/byte_serdes_core_tb_top.sv
`timescale 1ns/1ps
module byte_serdes_core_tb_top;
  logic clk = 1'b0;
  logic rst, loc_tick, rec_tick, fac_loop, eq_loop, eq_loop_hs, loop_time, rx_align, rx_ser_in;
  logic [7:0] tx_byte, rx_byte;
  logic tx_take, tx_ser_out, rx_stb;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  byte_serdes_core dut_i (
    .clk(clk), .rst(rst), .loc_tick(loc_tick), .rec_tick(rec_tick),
    .fac_loop(fac_loop), .eq_loop(eq_loop), .eq_loop_hs(eq_loop_hs),
    .loop_time(loop_time), .rx_align(rx_align), .tx_byte(tx_byte),
    .rx_ser_in(rx_ser_in), .tx_take(tx_take), .tx_ser_out(tx_ser_out),
    .rx_byte(rx_byte), .rx_stb(rx_stb)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] txb(input int k);
    return 8'((k * 29 + 60) ^ (k << 4));
  endfunction
  function automatic logic [7:0] rxb(input int k);
    return 8'(k * 53 + 145);
  endfunction
  function automatic logic rxbit(input int n);
    logic [7:0] b;
    b = rxb(n / 8);
    return b[7 - (n % 8)];
  endfunction
  function automatic logic [7:0] rx_word(input int start);
    logic [7:0] w;
    for (int j = 0; j < 8; j++) w[7-j] = rxbit(start + j);
    return w;
  endfunction

  task automatic apply_reset(input logic m_fac, m_eq, m_hs, m_lt);
    fac_loop = m_fac; eq_loop = m_eq; eq_loop_hs = m_hs; loop_time = m_lt;
    rst = 1'b1; rx_align = 1'b0; rx_ser_in = 1'b0; tx_byte = '0;
    loc_tick = 1'b1; rec_tick = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // Cycle-indexed driver/checker. Iteration i drives inputs for edge i and
  // sees outputs produced by edges up to i-1.
  task automatic run_core(input int n_it, input logic m_fac, m_eq, m_hs, m_lt,
                          input int loc_mode, rec_mode, align_at, rx_first,
                          input logic rx_from_tx, chk_tx, chk_fac,
                          input string tx_tag, rx_tag, fac_tag);
    int k_next;
    logic mbit;
    logic exp_ser [0:511];
    apply_reset(m_fac, m_eq, m_hs, m_lt);
    k_next = 0; mbit = 1'b0; exp_ser[0] = 1'b0; exp_ser[1] = 1'b0;
    for (int i = 0; i < n_it; i++) begin
      logic lt_i, rt_i, tt_i;
      logic [7:0] cur, want;
      int j;
      if (chk_tx) begin
        chk(tx_take === ((k_next % 8) == 0), tx_tag, tx_take, (k_next % 8) == 0);
        chk(tx_ser_out === exp_ser[i], tx_tag, tx_ser_out, exp_ser[i]);
      end
      if (chk_fac && i >= 3)
        chk(tx_ser_out === rxbit(i - 3), fac_tag, tx_ser_out, rxbit(i - 3));
      if (rx_first >= 0 && i >= rx_first) begin
        j = i - rx_first;
        want = rx_from_tx ? txb(j / 8) : rx_word(align_at - 1 + 8 * (j / 8));
        if ((j % 8) == 0) begin
          chk(rx_stb === 1'b1, rx_tag, rx_stb, 1);
          chk(rx_byte === want, rx_tag, rx_byte, want);
        end else begin
          chk(rx_stb === 1'b0, "R5", rx_stb, 0);
          chk(rx_byte === want, "R5", rx_byte, want);
        end
      end
      lt_i = (loc_mode == 1) ? ((i % 4) != 3) : 1'b1;
      rt_i = (rec_mode == 2) ? ((i % 3) != 1) : 1'b1;
      tt_i = m_lt ? rt_i : lt_i;
      loc_tick = lt_i; rec_tick = rt_i;
      rx_ser_in = m_hs ? ~rxbit(i * 7) : rxbit(i);
      rx_align = (i == align_at);
      cur = txb(k_next / 8);
      tx_byte = cur;
      if (tt_i) begin
        mbit = cur[7 - (k_next % 8)];
        k_next++;
      end
      exp_ser[i+2] = mbit;
      @(negedge clk);
    end
    rx_align = 1'b0;
  endtask

  task automatic t_reset;
    apply_reset(0, 0, 0, 0);
    rst = 1'b1;
    @(negedge clk);
    chk(tx_ser_out === 1'b0, "R10", tx_ser_out, 0);
    chk(rx_byte === 8'h00, "R10", rx_byte, 0);
    chk(rx_stb === 1'b0, "R10", rx_stb, 0);
    chk(tx_take === 1'b1, "R10", tx_take, 1);
    rst = 1'b0;
  endtask

  task automatic t_tx_serial;    // R1 with gapped local ticks
    run_core(130, 0, 0, 0, 0, 1, 0, -1, -1, 0, 1, 0, "R1", "R1", "R1");
  endtask
  task automatic t_loop_timing;  // R2: recovered tick drives serializer
    run_core(130, 0, 0, 0, 1, 1, 2, -1, -1, 0, 1, 0, "R2", "R2", "R2");
  endtask
  task automatic t_rx_latency;   // R4
    run_core(110, 0, 0, 0, 0, 0, 0, 1, 26, 0, 0, 0, "R4", "R4", "R4");
  endtask
  task automatic t_rx_realign;   // R3: shifted boundary
    run_core(110, 0, 0, 0, 0, 0, 0, 5, 30, 0, 0, 0, "R3", "R3", "R3");
  endtask
  task automatic t_facility;     // R6
    run_core(70, 1, 0, 0, 0, 0, 0, -1, -1, 0, 0, 1, "R6", "R6", "R6");
  endtask
  task automatic t_equipment;    // R7
    run_core(110, 0, 1, 0, 0, 0, 0, 0, 25, 1, 1, 0, "R7", "R7", "R7");
  endtask
  task automatic t_equip_hs;     // R8: external receive data ignored
    run_core(110, 0, 0, 1, 0, 0, 0, 2, 27, 1, 1, 0, "R8", "R8", "R8");
  endtask
  task automatic t_both_loops;   // R9
    run_core(110, 1, 1, 0, 0, 0, 0, 0, 25, 1, 0, 1, "R9", "R9", "R9");
  endtask

  initial begin
    #(5.0 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_tx_serial();
    t_loop_timing();
    t_rx_latency();
    t_rx_realign();
    t_facility();
    t_equipment();
    t_equip_hs();
    t_both_loops();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule